// File: doc/BRIEF.md
# Relocatable Dual-Port Local SRAM

This block is a word-organised on-chip memory with two access ports that work at the same time. Port A sits on the processor's local bus. Port B serves other bus masters, such as a DMA engine or a network controller. Each port compares the upper half of its 32-bit address with a programmable 16-bit base register. The memory can therefore be placed on any 64-Kbyte boundary of the 4-Gbyte space, and it stays disabled until software sets the base and its valid bit.

Each port accepts one request per cycle. Read data and the hit flag are registered and come out the cycle after the request. Writes take four byte enables, so byte, halfword and word stores change only the lanes they select. The two ports never stall each other. When both write the same word in the same cycle, the word is merged lane by lane and port A takes priority. When one port reads a word that the other port writes in the same cycle, the read returns the old contents.

The window is always 64 Kbytes. The number of populated words is set by `WORDS_LOG2`: 14 fills the window with 16K words of 32 bits, and smaller values leave the upper part of the window unpopulated. A request that misses, whether through a window mismatch, a clear valid bit or an offset outside the populated words, has no effect and returns zero.

Top module: `reloc_dual_sram`

## Requirements
- R1: After synchronous reset the base register is 0x0000 and the valid bit is clear. Every request then misses: `x_hit` is 0 and `x_rdata` is zero.
- R2: A cycle with `cfg_wr` high loads `cfg_base` and `cfg_valid`. The new values govern decoding from the next cycle on, and a request in the loading cycle is decoded against the old values.
- R3: A request hits only when all of these hold: `x_req` is high, the valid bit is set, `x_addr[31:16]` equals the base, and the word offset `x_addr[15:2]` is below 2^WORDS_LOG2. `x_hit` shows the outcome one cycle after the request.
- R4: A read that hits (`x_we` low) returns the word at offset `x_addr[15:2]` on `x_rdata` one cycle later. Missed requests and write requests return zero.
- R5: On a write, `x_be[i]` high replaces bits [8i+7:8i] of the word. Lanes whose enable is low keep their contents.
- R6: A write that misses leaves the memory unchanged.
- R7: Both ports can each complete one access per cycle on different words in the same cycle, with no stall.
- R8: When both ports write the same word in the same cycle, each lane enabled on port A takes port A's data. Each lane enabled only on port B takes port B's data. Other lanes are kept.
- R9: A read on one port of a word that the other port writes in the same cycle returns the contents from before that write.
- R10: Changing the base moves the window. Addresses in the old window miss, and the same stored words are reached through the new window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Load base and valid bit this cycle |
| cfg_base | input | 16 | New value for address bits [31:16] of the window |
| cfg_valid | input | 1 | New value of the enable bit |
| a_req | input | 1 | Port A request |
| a_we | input | 1 | Port A write (1) or read (0) |
| a_be | input | 4 | Port A byte enables, bit i selects bits [8i+7:8i] |
| a_addr | input | 32 | Port A byte address |
| a_wdata | input | 32 | Port A write data |
| a_rdata | output | 32 | Port A read data, one cycle after the request |
| a_hit | output | 1 | Port A request hit, one cycle after the request |
| b_req | input | 1 | Port B request |
| b_we | input | 1 | Port B write (1) or read (0) |
| b_be | input | 4 | Port B byte enables, bit i selects bits [8i+7:8i] |
| b_addr | input | 32 | Port B byte address |
| b_wdata | input | 32 | Port B write data |
| b_rdata | output | 32 | Port B read data, one cycle after the request |
| b_hit | output | 1 | Port B request hit, one cycle after the request |

## Verification
The bench aims at same-word collisions between the ports with partial byte enables. A design that wrote the two words one after the other would lose port B's lanes, or would let B override A. Reads that coincide with a write from the other port would return the new data if the read path looked through the write. Requests in the cycle that loads a new base would hit too early if the decoder used the incoming base rather than the stored one. Writes just outside the window, and offsets beyond the populated depth, would corrupt stored words if the decoder ignored any address bit. Relocating the base exposes a design that clears or re-indexes the storage when it moves the window.

// File: rtl/lsram_pkg.sv
package lsram_pkg;

    localparam int ADDR_W  = 32;
    localparam int DATA_W  = 32;
    localparam int LANES   = DATA_W / 8;
    localparam int WIN_LOG2 = 16;
    localparam int BASE_W  = ADDR_W - WIN_LOG2;
    localparam int OFF_W   = WIN_LOG2 - 2;
    localparam int NPORTS  = 2;

    typedef logic [DATA_W-1:0] word_t;
    typedef logic [BASE_W-1:0] base_t;

    typedef struct packed {
        logic              req;
        logic              we;
        logic [LANES-1:0]  be;
        logic [ADDR_W-1:0] addr;
        word_t             wdata;
    } bus_req_t;

    typedef struct packed {
        logic             hit;
        logic             wr;
        logic             rd;
        logic [OFF_W-1:0] idx;
        logic [LANES-1:0] be;
        word_t            wdata;
    } dec_t;

    typedef enum logic [1:0] {
        WR_IDLE,
        WR_SPLIT,
        WR_JOINED
    } wr_plan_e;

    function automatic word_t lane_merge(input word_t old_w, input word_t new_w,
                                         input logic [LANES-1:0] be);
        word_t r;
        r = old_w;
        for (int i = 0; i < LANES; i++) begin
            if (be[i]) r[8*i +: 8] = new_w[8*i +: 8];
        end
        return r;
    endfunction

    function automatic logic window_match(input logic [ADDR_W-1:0] addr, input base_t base);
        return addr[ADDR_W-1:WIN_LOG2] == base;
    endfunction

endpackage

// File: rtl/lsram_base_reg.sv
module lsram_base_reg
    import lsram_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  cfg_wr,
    input  base_t cfg_base,
    input  logic  cfg_valid,
    output base_t base_q,
    output logic  valid_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            base_q  <= '0;
            valid_q <= 1'b0;
        end else if (cfg_wr) begin
            base_q  <= cfg_base;
            valid_q <= cfg_valid;
        end
    end
endmodule

// File: rtl/lsram_decode.sv
module lsram_decode
    import lsram_pkg::*;
#(
    parameter int WORDS_LOG2 = 11
) (
    input  bus_req_t req_i,
    input  base_t    base_i,
    input  logic     valid_i,
    output dec_t     dec_o
);
    logic in_range;
    logic hit;

    if (WORDS_LOG2 < OFF_W) begin : g_partial
        assign in_range = (req_i.addr[WIN_LOG2-1:WORDS_LOG2+2] == '0);
    end else begin : g_full
        assign in_range = 1'b1;
    end

    assign hit = req_i.req && valid_i && in_range && window_match(req_i.addr, base_i);

    always_comb begin
        dec_o.hit   = hit;
        dec_o.wr    = hit && req_i.we;
        dec_o.rd    = hit && !req_i.we;
        dec_o.idx   = req_i.addr[WIN_LOG2-1:2];
        dec_o.be    = req_i.be;
        dec_o.wdata = req_i.wdata;
    end
endmodule

// File: rtl/lsram_core.sv
module lsram_core
    import lsram_pkg::*;
#(
    parameter int WORDS_LOG2 = 11
) (
    input  logic  clk,
    input  logic  rst,
    input  dec_t  dec_a,
    input  dec_t  dec_b,
    output word_t rdata_a,
    output word_t rdata_b,
    output logic  hit_a,
    output logic  hit_b
);
    localparam int DEPTH = 1 << WORDS_LOG2;

    word_t mem [DEPTH];

    logic [WORDS_LOG2-1:0] ia, ib;
    wr_plan_e plan;
    word_t    joined;

    assign ia = dec_a.idx[WORDS_LOG2-1:0];
    assign ib = dec_b.idx[WORDS_LOG2-1:0];

    always_comb begin
        if (dec_a.wr && dec_b.wr && ia == ib)      plan = WR_JOINED;
        else if (dec_a.wr || dec_b.wr)             plan = WR_SPLIT;
        else                                       plan = WR_IDLE;
        // port A lanes applied last so they take priority
        joined = lane_merge(lane_merge(mem[ia], dec_b.wdata, dec_b.be), dec_a.wdata, dec_a.be);
    end

    always_ff @(posedge clk) begin
        case (plan)
            WR_JOINED: mem[ia] <= joined;
            WR_SPLIT: begin
                if (dec_a.wr) mem[ia] <= lane_merge(mem[ia], dec_a.wdata, dec_a.be);
                if (dec_b.wr) mem[ib] <= lane_merge(mem[ib], dec_b.wdata, dec_b.be);
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_a <= '0;
            rdata_b <= '0;
            hit_a   <= 1'b0;
            hit_b   <= 1'b0;
        end else begin
            rdata_a <= dec_a.rd ? mem[ia] : '0;
            rdata_b <= dec_b.rd ? mem[ib] : '0;
            hit_a   <= dec_a.hit;
            hit_b   <= dec_b.hit;
        end
    end
endmodule

// File: rtl/reloc_dual_sram.sv
module reloc_dual_sram
    import lsram_pkg::*;
#(
    parameter int WORDS_LOG2 = 11
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_wr,
    input  logic [15:0] cfg_base,
    input  logic        cfg_valid,
    input  logic        a_req,
    input  logic        a_we,
    input  logic [3:0]  a_be,
    input  logic [31:0] a_addr,
    input  logic [31:0] a_wdata,
    output logic [31:0] a_rdata,
    output logic        a_hit,
    input  logic        b_req,
    input  logic        b_we,
    input  logic [3:0]  b_be,
    input  logic [31:0] b_addr,
    input  logic [31:0] b_wdata,
    output logic [31:0] b_rdata,
    output logic        b_hit
);
    base_t    base_q;
    logic     valid_q;
    bus_req_t req [NPORTS];
    dec_t     dec [NPORTS];

    assign req[0] = '{req: a_req, we: a_we, be: a_be, addr: a_addr, wdata: a_wdata};
    assign req[1] = '{req: b_req, we: b_we, be: b_be, addr: b_addr, wdata: b_wdata};

    lsram_base_reg u_base (
        .clk      (clk),
        .rst      (rst),
        .cfg_wr   (cfg_wr),
        .cfg_base (cfg_base),
        .cfg_valid(cfg_valid),
        .base_q   (base_q),
        .valid_q  (valid_q)
    );

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        lsram_decode #(.WORDS_LOG2(WORDS_LOG2)) u_dec (
            .req_i  (req[p]),
            .base_i (base_q),
            .valid_i(valid_q),
            .dec_o  (dec[p])
        );
    end

    lsram_core #(.WORDS_LOG2(WORDS_LOG2)) u_core (
        .clk    (clk),
        .rst    (rst),
        .dec_a  (dec[0]),
        .dec_b  (dec[1]),
        .rdata_a(a_rdata),
        .rdata_b(b_rdata),
        .hit_a  (a_hit),
        .hit_b  (b_hit)
    );
endmodule

// File: rtl/lsram_checker.sv
module lsram_checker (
    input logic        clk,
    input logic        rst,
    input logic        cfg_wr,
    input logic [15:0] cfg_base,
    input logic        cfg_valid,
    input logic        a_req,
    input logic        b_req,
    input logic        a_hit,
    input logic        b_hit,
    input logic [31:0] a_rdata,
    input logic [31:0] b_rdata,
    input logic [15:0] base_q,
    input logic        valid_q
);
    // R1: reset clears base and valid
    p_reset_clear_r1: assert property (@(posedge clk) rst |=> (base_q == 16'h0 && !valid_q));

    // R2: configuration write lands in the register next cycle
    p_cfg_load_r2: assert property (@(posedge clk) disable iff (rst)
        cfg_wr |=> (base_q == $past(cfg_base) && valid_q == $past(cfg_valid)));

    // R3: no hit while disabled
    p_no_hit_invalid_r3: assert property (@(posedge clk) disable iff (rst)
        !valid_q |=> (!a_hit && !b_hit));

    // R3: no hit without a request
    p_hit_needs_req_a_r3: assert property (@(posedge clk) disable iff (rst) !a_req |=> !a_hit);
    p_hit_needs_req_b_r3: assert property (@(posedge clk) disable iff (rst) !b_req |=> !b_hit);

    // R4: nonzero read data only on a hit
    p_miss_zero_a_r4: assert property (@(posedge clk) disable iff (rst) (a_rdata != 32'h0) |-> a_hit);
    p_miss_zero_b_r4: assert property (@(posedge clk) disable iff (rst) (b_rdata != 32'h0) |-> b_hit);
endmodule

bind reloc_dual_sram lsram_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .cfg_wr   (cfg_wr),
    .cfg_base (cfg_base),
    .cfg_valid(cfg_valid),
    .a_req    (a_req),
    .b_req    (b_req),
    .a_hit    (a_hit),
    .b_hit    (b_hit),
    .a_rdata  (a_rdata),
    .b_rdata  (b_rdata),
    .base_q   (base_q),
    .valid_q  (valid_q)
);

// File: tb/reloc_dual_sram_tb.sv
`timescale 1ns/1ps
module reloc_dual_sram_tb;
    localparam int WL = 11;
    localparam int DEPTH = 1 << WL;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr = 1'b0;
    logic [15:0] cfg_base = '0;
    logic        cfg_valid = 1'b0;
    logic        a_req = 1'b0, a_we = 1'b0, b_req = 1'b0, b_we = 1'b0;
    logic [3:0]  a_be = '0, b_be = '0;
    logic [31:0] a_addr = '0, a_wdata = '0, b_addr = '0, b_wdata = '0;
    logic [31:0] a_rdata, b_rdata;
    logic        a_hit, b_hit;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 1'b0;

    logic [31:0] model [DEPTH];
    logic [15:0] mbase = '0;
    logic        mvalid = 1'b0;

    always #4 clk = ~clk;

    reloc_dual_sram #(.WORDS_LOG2(WL)) u_dut (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_base(cfg_base), .cfg_valid(cfg_valid),
        .a_req(a_req), .a_we(a_we), .a_be(a_be), .a_addr(a_addr), .a_wdata(a_wdata),
        .a_rdata(a_rdata), .a_hit(a_hit),
        .b_req(b_req), .b_we(b_we), .b_be(b_be), .b_addr(b_addr), .b_wdata(b_wdata),
        .b_rdata(b_rdata), .b_hit(b_hit)
    );

    function automatic logic f_hit(input logic req, input logic [31:0] addr);
        return req && mvalid && addr[31:16] == mbase && addr[15:2] < DEPTH;
    endfunction

    function automatic logic [31:0] f_merge(input logic [31:0] o, input logic [31:0] n,
                                            input logic [3:0] be);
        logic [31:0] r = o;
        for (int i = 0; i < 4; i++) if (be[i]) r[8*i +: 8] = n[8*i +: 8];
        return r;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle();
        cfg_wr = 1'b0; a_req = 1'b0; b_req = 1'b0;
    endtask

    task automatic set_a(input logic we, input logic [3:0] be, input logic [31:0] ad, input logic [31:0] d);
        a_req = 1'b1; a_we = we; a_be = be; a_addr = ad; a_wdata = d;
    endtask

    task automatic set_b(input logic we, input logic [3:0] be, input logic [31:0] ad, input logic [31:0] d);
        b_req = 1'b1; b_we = we; b_be = be; b_addr = ad; b_wdata = d;
    endtask

    // one clock: predict from current inputs, update model, compare after the edge
    task automatic run(input string ta, input string tb);
        logic ha, hb;
        logic [31:0] ea, eb;
        ha = f_hit(a_req, a_addr);
        hb = f_hit(b_req, b_addr);
        ea = (ha && !a_we) ? model[a_addr[WL+1:2]] : 32'h0;
        eb = (hb && !b_we) ? model[b_addr[WL+1:2]] : 32'h0;
        if (hb && b_we) model[b_addr[WL+1:2]] = f_merge(model[b_addr[WL+1:2]], b_wdata, b_be);
        if (ha && a_we) model[a_addr[WL+1:2]] = f_merge(model[a_addr[WL+1:2]], a_wdata, a_be);
        if (cfg_wr) begin mbase = cfg_base; mvalid = cfg_valid; end
        @(negedge clk);
        chk({ta, " a_hit"}, {31'h0, a_hit}, {31'h0, ha});
        chk({ta, " a_rdata"}, a_rdata, ea);
        chk({tb, " b_hit"}, {31'h0, b_hit}, {31'h0, hb});
        chk({tb, " b_rdata"}, b_rdata, eb);
        idle();
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk("R1 a_hit in reset", {31'h0, a_hit}, 32'h0);
        chk("R1 b_rdata in reset", b_rdata, 32'h0);
        rst = 1'b0;
        // R1: base 0 but disabled, address 0 misses
        set_a(1'b1, 4'hF, 32'h0000_0000, 32'h1234_5678);
        set_b(1'b0, 4'hF, 32'h0000_0004, 32'h0);
        run("R1", "R1");

        // R2: request in the loading cycle uses old (disabled) state
        cfg_wr = 1'b1; cfg_base = 16'h2002; cfg_valid = 1'b1;
        set_a(1'b1, 4'hF, 32'h2002_0000, 32'hCAFE_0000);
        run("R2", "R2");

        // preload every word
        for (int i = 0; i < DEPTH; i++) begin
            set_a(1'b1, 4'hF, 32'h2002_0000 + 32'(i * 4), 32'(i) * 32'h9E37_79B1 ^ 32'hA5A5_0000);
            run("R4 preload", "R4 preload");
        end
        set_a(1'b0, 4'h0, 32'h2002_0000, 32'h0);
        set_b(1'b0, 4'h0, 32'h2002_0000 + 32'((DEPTH - 1) * 4), 32'h0);
        run("R4", "R4");

        // R6: writes outside the window change nothing
        set_a(1'b1, 4'hF, 32'h2003_0010, 32'hDEAD_BEEF);
        set_b(1'b1, 4'hF, 32'h2001_0010, 32'hFEED_F00D);
        run("R6", "R6");
        set_a(1'b0, 4'h0, 32'h2002_0010, 32'h0);
        run("R6", "R6");

        // R3: offset beyond populated depth misses, read and write
        set_a(1'b1, 4'hF, 32'h2002_8010, 32'h0BAD_0BAD);
        set_b(1'b0, 4'h0, 32'h2002_FFFC, 32'h0);
        run("R3", "R3");
        set_a(1'b0, 4'h0, 32'h2002_0010, 32'h0);
        run("R3", "R3");

        // R5: single byte and halfword stores
        set_a(1'b1, 4'b0010, 32'h2002_0014, 32'h1122_3344);
        set_b(1'b1, 4'b1100, 32'h2002_0018, 32'h5566_7788);
        run("R5", "R5");
        set_a(1'b0, 4'h0, 32'h2002_0014, 32'h0);
        set_b(1'b0, 4'h0, 32'h2002_0018, 32'h0);
        run("R5", "R5");

        // R8: same-word collision, overlapping lane 1
        set_a(1'b1, 4'b0011, 32'h2002_001C, 32'hAAAA_AAAA);
        set_b(1'b1, 4'b0110, 32'h2002_001C, 32'hBBBB_BBBB);
        run("R8", "R8");
        set_a(1'b0, 4'h0, 32'h2002_001C, 32'h0);
        run("R8", "R8");

        // R9: read while the other port writes the same word, both directions
        set_a(1'b0, 4'h0, 32'h2002_0024, 32'h0);
        set_b(1'b1, 4'hF, 32'h2002_0024, 32'h9999_0001);
        run("R9", "R9");
        set_a(1'b1, 4'hF, 32'h2002_0028, 32'h7777_0002);
        set_b(1'b0, 4'h0, 32'h2002_0028, 32'h0);
        run("R9", "R9");
        set_a(1'b0, 4'h0, 32'h2002_0028, 32'h0);
        set_b(1'b0, 4'h0, 32'h2002_0024, 32'h0);
        run("R9", "R9");

        // R7: both ports active on different words
        set_a(1'b1, 4'hF, 32'h2002_0030, 32'h3030_3030);
        set_b(1'b0, 4'h0, 32'h2002_0034, 32'h0);
        run("R7", "R7");

        // R10 with R2: relocate; request in loading cycle still uses old base
        cfg_wr = 1'b1; cfg_base = 16'hFFFF; cfg_valid = 1'b1;
        set_a(1'b0, 4'h0, 32'h2002_0014, 32'h0);
        set_b(1'b0, 4'h0, 32'hFFFF_0014, 32'h0);
        run("R2", "R2");
        set_a(1'b0, 4'h0, 32'h2002_0014, 32'h0);
        set_b(1'b0, 4'h0, 32'hFFFF_0014, 32'h0);
        run("R10", "R10");

        // R3: disable, then re-enable
        cfg_wr = 1'b1; cfg_base = 16'hFFFF; cfg_valid = 1'b0;
        run("R3", "R3");
        set_a(1'b0, 4'h0, 32'hFFFF_0014, 32'h0);
        run("R3", "R3");
        cfg_wr = 1'b1; cfg_base = 16'hFFFF; cfg_valid = 1'b1;
        run("R2", "R2");

        // random mixed traffic in a narrow range to force collisions
        for (int n = 0; n < 4000; n++) begin
            for (int p = 0; p < 2; p++) begin
                logic [31:0] ad;
                logic [31:0] r;
                r  = $urandom();
                ad = {16'hFFFF, 16'h0} | 32'(($urandom() % 32) * 4);
                if (r[2:0] == 3'd0) ad[31:16] = 16'hFFFE;
                if (r[6:3] == 4'd0) ad[15] = 1'b1;
                if (p == 0) begin
                    if (r[9:8] != 2'd0) set_a(r[10], r[14:11], ad, $urandom());
                end else begin
                    if (r[9:8] != 2'd0) set_b(r[10], r[14:11], ad, $urandom());
                end
            end
            run("R7 R8 R9 random", "R7 R8 R9 random");
        end

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule